// File: doc/BRIEF.md
# Keyed Configuration Port with Banked Device Registers

This block is the configuration front end of a multi-function peripheral chip. A host reaches it through two byte-wide I/O addresses: an index port, which names a configuration register, and a data port, which reads or writes the register that was named. After reset the port is locked. It opens only when four key bytes arrive at the index port in the right order. A write of the exit value through the data port locks it again.

Once the port is open, a device-select register picks one of several device banks. Each bank holds an enable bit and a 16-bit I/O base address. The same index numbers reach the registers of whichever bank is selected. There is also a read-only identity area that gives a chip identifier and a revision. The block drives the selected device number, that bank's enable bit and that bank's base address as outputs, for use by the logic behind the banks.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked (`cfg_mode` low). The bytes 0x87, 0x01, 0x55 and 0x55, written in that order to the index port (0x2E), unlock it. `cfg_mode` goes high on the clock edge that takes the last key byte, and the index register is then 0x00.
- R2: While locked, an index-port byte that does not match the next key byte restarts key matching. If that byte is 0x87, matching restarts at the second key byte instead.
- R3: While locked, data-port (0x2F) writes have no effect, and reads of either port return 0xFF.
- R4: While unlocked, an index-port write stores the register number. An index-port read returns that number.
- R5: While unlocked, writing 0x02 through the data port with index 0x02 selected locks the port. Any other value written at index 0x02 leaves it unlocked.
- R6: Index 0x07 is the read/write device-select register. Its value appears on `sel_dev` and chooses the bank that indices 0x30, 0x60 and 0x61 address.
- R7: Index 0x20 reads the high byte of the chip identifier and 0x21 the low byte. Index 0x22 reads the revision in bits 3:0, with bits 7:4 zero. Writes to these indices have no effect.
- R8: Index 0x30 holds the selected bank's enable in bit 0. Bits 7:1 read as 0. `sel_active` shows the selected bank's enable bit.
- R9: Index 0x60 holds the high byte of the selected bank's base address and 0x61 the low byte. `sel_base` shows the whole 16-bit value.
- R10: Every other index reads 0x00. When the device-select value is NUM_DEV or more, the bank indices read 0x00, writes to them have no effect, and `sel_active` and `sel_base` are 0.
- R11: `io_rdata` is combinational and is 0x00 when `io_rd` is low. A read made in the same cycle as a write to the same register returns the old value. The new value is visible from the next cycle.
- R12: Reset clears the device select and every bank's enable and base address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| cfg_mode | output | 1 | High while the port is unlocked |
| sel_dev | output | 8 | Current device-select value |
| sel_active | output | 1 | Enable bit of the selected bank |
| sel_base | output | 16 | Base address of the selected bank |

## Verification
A data-port read and a data-port write can land in the same cycle on the same register. The bench raises `io_rd` and `io_wr` together while the base-address high byte is selected, with a new value on `io_wdata`. It expects the read to return the byte stored before that cycle, and a read in the next cycle to return the new byte. The same overlap is also tried on the exit index: the read returns 0x00 and `cfg_mode` drops on the following edge.

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port #(
  parameter logic [15:0] INDEX_ADDR = 16'h002E,
  parameter logic [15:0] DATA_ADDR  = 16'h002F,
  parameter logic [15:0] CHIP_ID    = 16'h8716,
  parameter logic [3:0]  CHIP_REV   = 4'h2,
  parameter int          NUM_DEV    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        cfg_mode,
  output logic [7:0]  sel_dev,
  output logic        sel_active,
  output logic [15:0] sel_base
);
  localparam int BW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic [1:0]  step;
  logic [7:0]  idx;
  logic [7:0]  key_byte;
  logic [7:0]  reg_val;
  logic        act_q  [NUM_DEV];
  logic [15:0] base_q [NUM_DEV];

  wire idx_wr  = io_wr && (io_addr == INDEX_ADDR);
  wire dat_wr  = io_wr && (io_addr == DATA_ADDR);
  wire idx_rd  = io_rd && (io_addr == INDEX_ADDR);
  wire dat_rd  = io_rd && (io_addr == DATA_ADDR);
  wire dev_ok  = (32'(sel_dev) < NUM_DEV);
  wire [BW-1:0] bsel = BW'(sel_dev);

  always_comb
    case (step)
      2'd0:    key_byte = 8'h87;
      2'd1:    key_byte = 8'h01;
      default: key_byte = 8'h55;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_mode <= 1'b0;
      step     <= 2'd0;
      idx      <= 8'h00;
      sel_dev  <= 8'h00;
    end else if (!cfg_mode) begin
      if (idx_wr) begin
        if (io_wdata == key_byte) begin
          if (step == 2'd3) begin
            cfg_mode <= 1'b1;
            step     <= 2'd0;
            idx      <= 8'h00;
          end else
            step <= step + 2'd1;
        end else
          step <= (io_wdata == 8'h87) ? 2'd1 : 2'd0;
      end
    end else begin
      if (idx_wr) idx <= io_wdata;
      if (dat_wr && idx == 8'h02 && io_wdata == 8'h02) cfg_mode <= 1'b0;
      if (dat_wr && idx == 8'h07) sel_dev <= io_wdata;
    end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
    wire hit = cfg_mode && dat_wr && dev_ok && (bsel == BW'(g));
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        act_q[g]  <= 1'b0;
        base_q[g] <= 16'h0000;
      end else if (hit) begin
        if (idx == 8'h30) act_q[g]         <= io_wdata[0];
        if (idx == 8'h60) base_q[g][15:8]  <= io_wdata;
        if (idx == 8'h61) base_q[g][7:0]   <= io_wdata;
      end
  end

  assign sel_active = dev_ok && act_q[bsel];
  assign sel_base   = dev_ok ? base_q[bsel] : 16'h0000;

  always_comb
    case (idx)
      8'h07:   reg_val = sel_dev;
      8'h20:   reg_val = CHIP_ID[15:8];
      8'h21:   reg_val = CHIP_ID[7:0];
      8'h22:   reg_val = {4'h0, CHIP_REV};
      8'h30:   reg_val = {7'd0, sel_active};
      8'h60:   reg_val = sel_base[15:8];
      8'h61:   reg_val = sel_base[7:0];
      default: reg_val = 8'h00;
    endcase

  assign io_rdata = !cfg_mode && (idx_rd || dat_rd) ? 8'hFF :
                    idx_rd ? idx :
                    dat_rd ? reg_val : 8'h00;

  // R1
  unlock_on_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_mode) |-> $past(idx_wr && io_wdata == 8'h55 && step == 2'd3));

  // R3
  locked_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && dat_wr) |=> ($stable(sel_dev) && $stable(sel_base) && $stable(sel_active)));

  // R3
  locked_reads_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && dat_rd) |-> io_rdata == 8'hFF);

  // R5
  exit_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_mode) |-> $past(dat_wr && idx == 8'h02 && io_wdata == 8'h02));

  // R10
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_ok |-> (!sel_active && sel_base == 16'h0000));

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'h00);
endmodule

// File: tb/test_keyed_cfg_port.sv
`timescale 1ns/1ps
module test_keyed_cfg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata;
  logic        cfg_mode;
  logic [7:0]  sel_dev;
  logic        sel_active;
  logic [15:0] sel_base;
  int n_chk = 0;
  int n_bad = 0;

  localparam logic [15:0] IP = 16'h002E;
  localparam logic [15:0] DP = 16'h002F;

  always #2.5 clk = ~clk;

  keyed_cfg_port i_keyed_cfg_port (.*);

  // {write, data_port, byte, expected}
  localparam int NV = 22;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 8'h00},  // R1: index 0x00 after unlock
    {1'b1, 1'b0, 8'h20, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h87},  // R7
    {1'b1, 1'b0, 8'h21, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h16},  // R7
    {1'b1, 1'b1, 8'hAA, 8'h00},  // R7 ignored write
    {1'b0, 1'b1, 8'h00, 8'h16},  // R7
    {1'b1, 1'b0, 8'h22, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h02},  // R7
    {1'b0, 1'b0, 8'h00, 8'h22},  // R4
    {1'b1, 1'b0, 8'h07, 8'h00},
    {1'b1, 1'b1, 8'h03, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h03},  // R6
    {1'b1, 1'b0, 8'h30, 8'h00},
    {1'b1, 1'b1, 8'hFF, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h01},  // R8
    {1'b1, 1'b0, 8'h60, 8'h00},
    {1'b1, 1'b1, 8'h12, 8'h00},
    {1'b1, 1'b0, 8'h61, 8'h00},
    {1'b1, 1'b1, 8'h34, 8'h00},
    {1'b1, 1'b0, 8'h55, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h00}   // R10
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic unlock();
    wr(IP, 8'h87); wr(IP, 8'h01); wr(IP, 8'h55); wr(IP, 8'h55);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    check("R12 cfg_mode", {15'd0, cfg_mode}, 16'd0);
    check("R12 sel_dev", {8'd0, sel_dev}, 16'd0);
    check("R12 sel_base", sel_base, 16'd0);
    // R3 locked reads and writes
    rd(DP, d); check("R3 data read", {8'd0, d}, 16'h00FF);
    rd(IP, d); check("R3 index read", {8'd0, d}, 16'h00FF);
    wr(DP, 8'h07); wr(DP, 8'h05);
    check("R3 sel_dev", {8'd0, sel_dev}, 16'd0);
    // R2 broken sequence
    wr(IP, 8'h87); wr(IP, 8'h01); wr(IP, 8'h55); wr(IP, 8'h00);
    check("R2 broken", {15'd0, cfg_mode}, 16'd0);
    wr(IP, 8'h55); wr(IP, 8'h55);
    check("R2 no resume", {15'd0, cfg_mode}, 16'd0);
    // R2 0x87 restarts at step two
    wr(IP, 8'h87); wr(IP, 8'h01); wr(IP, 8'h87); wr(IP, 8'h01); wr(IP, 8'h55);
    check("R2 partial", {15'd0, cfg_mode}, 16'd0);
    wr(IP, 8'h55);
    check("R1 R2 unlocked", {15'd0, cfg_mode}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][17]) wr(VEC[i][16] ? DP : IP, VEC[i][15:8]);
      else begin
        rd(VEC[i][16] ? DP : IP, d);
        check($sformatf("vector %0d", i), {8'd0, d}, {8'd0, VEC[i][7:0]});
      end
    end
    check("R9 sel_base", sel_base, 16'h1234);
    check("R8 sel_active", {15'd0, sel_active}, 16'd1);
    check("R6 sel_dev", {8'd0, sel_dev}, 16'd3);

    // R11 simultaneous read and write
    wr(IP, 8'h60);
    @(negedge clk);
    io_addr = DP; io_wdata = 8'h56; io_wr = 1'b1; io_rd = 1'b1;
    #1 d = io_rdata;
    check("R11 old value", {8'd0, d}, 16'h0012);
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    rd(DP, d); check("R11 new value", {8'd0, d}, 16'h0056);

    // R10 out-of-range bank
    wr(IP, 8'h07); wr(DP, 8'h14);
    check("R10 active", {15'd0, sel_active}, 16'd0);
    check("R10 base", sel_base, 16'd0);
    wr(IP, 8'h30); wr(DP, 8'h01);
    rd(DP, d); check("R10 read", {8'd0, d}, 16'd0);
    wr(IP, 8'h07); wr(DP, 8'h03);
    check("R10 bank kept", sel_base, 16'h5634);
    wr(IP, 8'h07); wr(DP, 8'h04);
    check("R6 other bank", {15'd0, sel_active}, 16'd0);

    // R5 exit
    wr(IP, 8'h02); wr(DP, 8'h03);
    check("R5 wrong value", {15'd0, cfg_mode}, 16'd1);
    @(negedge clk);
    io_addr = DP; io_wdata = 8'h02; io_wr = 1'b1; io_rd = 1'b1;
    #1 d = io_rdata;
    check("R5 R11 read at exit", {8'd0, d}, 16'd0);
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    check("R5 locked", {15'd0, cfg_mode}, 16'd0);
    rd(DP, d); check("R5 R3 read after exit", {8'd0, d}, 16'h00FF);
    // R12 reset clears banks
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    unlock();
    wr(IP, 8'h07); wr(DP, 8'h03);
    check("R12 bank cleared", sel_base, 16'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule